// File: doc/BRIEF.md
# Power-domain gating sequencer

This block switches one gated power domain off and back on under software control. Software uses a small register bus to enable gating, to program two delays for each direction, and to post a power-down or power-up request. The block then runs a timed two-phase sequence. Going down, it first clamps the isolation cells and, after the first delay, opens the power switch. Going up, it first closes the switch and, after the first delay, releases isolation. In each direction a second delay follows the second step before the sequence is reported complete.

Each delay is a 6-bit count of bus-clock cycles, and a field of zero gives a one-cycle phase. A request bit stays set while its sequence runs and clears itself when the sequence finishes, so software can poll it. The block also drives a busy level and a one-cycle done pulse. A request that cannot act or has nothing to do retires at once. A power-down request is also blocked while gating is disabled. If both requests arrive together, power-down runs first and the power-up request then runs from the pending bit.

Top module: `pwr_gate_seq`

## Requirements
- R1: After reset, `sw_en`=1 (domain powered) and `iso_en`=0. `busy`=0 and `done`=0. The gate-enable register reads 0, both timing registers read 0x0000_0101 (every delay field is 1), and the control register reads 0.
- R2: Register map on `bus_addr`: 0x000 control, where bit 0 requests power-down and bit 1 requests power-up, writing 1 sets a bit, writing 0 has no effect, and a read returns the pending bits. 0x260 gate enable (bit 0). 0x264 power-up timing: bits [5:0] are the switch delay U1 and bits [13:8] are the switch-to-isolation delay U2. 0x268 power-down timing: bits [5:0] are the isolation delay D1 and bits [13:8] are the isolation-to-switch delay D2. Unimplemented bits and unmapped addresses read 0.
- R3: A power-down request is latched by a write at clock edge T0. With gating enabled and the domain powered, `iso_en` rises at edge T0+1 and `sw_en` falls max(D1,1) edges later.
- R4: max(D2,1) edges after `sw_en` falls, the power-down ends: `done` is 1 for one cycle, `busy` returns to 0, and control bit 0 reads 0. `busy` is 1 from T0+1 until then.
- R5: A power-up request is latched at T0 while the domain is off. `sw_en` rises at T0+1 and `iso_en` falls max(U1,1) edges later.
- R6: max(U2,1) edges after `iso_en` falls, the power-up ends: `done` pulses, `busy` drops, and control bit 1 reads 0.
- R7: A power-down request with gate-enable bit 0 at 0 retires at T0+1: `done` pulses, bit 0 clears, and `iso_en` and `sw_en` do not change. Gate enable has no effect on power-up.
- R8: A request that matches the current state (power-up while powered, power-down while off) retires at T0+1 with a `done` pulse and no output change.
- R9: When both request bits are set by one write, power-down runs first with bit 1 still pending. When the power-down finishes, control reads 0x2. The power-up then starts one edge after the power-down finishes.
- R10: A delay field of 0 behaves as 1, so each phase lasts at least one cycle. The largest field value, 63, gives a 63-cycle phase.
- R11: `iso_en` is 1 whenever `sw_en` is 0. The switch opens only while isolation is already on, and isolation is released only while the switch is already closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all delays count its cycles |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| iso_en | output | 1 | 1 clamps the domain's isolation cells |
| sw_en | output | 1 | 1 closes the power switch (domain powered) |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse when a request completes or retires |

## Verification
A wrong phase state or a wrong counter load shows at the pins within one phase. `iso_en` or `sw_en` moves on the wrong edge, or the `done` pulse arrives early or late by a cycle count that the bench measures exactly. A corrupted request bit shows at the next control-register read, or as a sequence that starts or retires when it should not. An ordering fault, where the switch opens without isolation, breaks the safety relation between the two outputs on the same edge. Running zero, small and full-scale delays in both directions separates a wrong field from an off-by-one in the counter.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int DLY_W  = 6;
    localparam int HI_LSB = 8;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_GATE = 12'h260;
    localparam logic [ADDR_W-1:0] OFS_UPT  = 12'h264;
    localparam logic [ADDR_W-1:0] OFS_DNT  = 12'h268;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DN_ISO,
        ST_DN_SW,
        ST_UP_SW,
        ST_UP_ISO
    } seq_state_t;

    // lead = low field (first phase), tail = high field (second phase)
    typedef struct packed {
        logic [DLY_W-1:0] tail;
        logic [DLY_W-1:0] lead;
    } phase_dly_t;

    // bit 1 power-up, bit 0 power-down
    typedef struct packed {
        logic req_up;
        logic req_dn;
    } req_t;

    // counter preload: a phase of d cycles (d=0 treated as 1) loads d-1
    function automatic logic [DLY_W-1:0] load_val(input logic [DLY_W-1:0] d);
        return (d == '0) ? '0 : d - 1'b1;
    endfunction

    function automatic logic [DATA_W-1:0] pack_dly(input phase_dly_t p);
        logic [DATA_W-1:0] w;
        w = '0;
        w[DLY_W-1:0]         = p.lead;
        w[HI_LSB +: DLY_W]   = p.tail;
        return w;
    endfunction

endpackage

// File: rtl/pgs_regs.sv
module pgs_regs
    import pgs_pkg::*;
#(
    parameter logic [DLY_W-1:0] DLY_RST = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              gate_en,
    output phase_dly_t        up_dly,
    output phase_dly_t        dn_dly,
    output req_t              req,
    input  req_t              clr
);

    logic [1:0] req_q;
    logic [1:0] set_bits;

    assign set_bits = (bus_we && bus_addr == OFS_CTRL) ? bus_wdata[1:0] : 2'b00;
    assign req      = req_t'(req_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_en     <= 1'b0;
            up_dly.lead <= DLY_RST;
            up_dly.tail <= DLY_RST;
            dn_dly.lead <= DLY_RST;
            dn_dly.tail <= DLY_RST;
            req_q       <= 2'b00;
        end else begin
            req_q <= (req_q & ~{clr.req_up, clr.req_dn}) | set_bits;
            if (bus_we) begin
                case (bus_addr)
                    OFS_GATE: gate_en <= bus_wdata[0];
                    OFS_UPT: begin
                        up_dly.lead <= bus_wdata[DLY_W-1:0];
                        up_dly.tail <= bus_wdata[HI_LSB +: DLY_W];
                    end
                    OFS_DNT: begin
                        dn_dly.lead <= bus_wdata[DLY_W-1:0];
                        dn_dly.tail <= bus_wdata[HI_LSB +: DLY_W];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL: bus_rdata[1:0] = req_q;
            OFS_GATE: bus_rdata[0]   = gate_en;
            OFS_UPT:  bus_rdata      = pack_dly(up_dly);
            OFS_DNT:  bus_rdata      = pack_dly(dn_dly);
            default:  bus_rdata      = '0;
        endcase
    end

    // R2
    clr_dn_pending_chk: assert property (@(posedge clk) disable iff (rst)
        clr.req_dn |-> req_q[0]);
    // R2
    clr_up_pending_chk: assert property (@(posedge clk) disable iff (rst)
        clr.req_up |-> req_q[1]);

endmodule

// File: rtl/pgs_phase_cnt.sv
module pgs_phase_cnt
    import pgs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DLY_W-1:0] load_v,
    output logic             expired
);

    logic [DLY_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_v;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R10
    cnt_down_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/pgs_seq.sv
module pgs_seq
    import pgs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  req_t       req,
    input  logic       gate_en,
    input  phase_dly_t up_dly,
    input  phase_dly_t dn_dly,
    output req_t       clr,
    output logic       iso_en,
    output logic       sw_en,
    output logic       busy,
    output logic       done
);

    seq_state_t       state, state_n;
    logic             iso_n, sw_n, done_n;
    logic             ld;
    logic [DLY_W-1:0] ld_v;
    logic             expired;

    pgs_phase_cnt u_cnt (
        .clk     (clk),
        .rst     (rst),
        .load    (ld),
        .load_v  (ld_v),
        .expired (expired)
    );

    always_comb begin
        state_n = state;
        iso_n   = iso_en;
        sw_n    = sw_en;
        done_n  = 1'b0;
        ld      = 1'b0;
        ld_v    = '0;
        clr     = '0;
        case (state)
            ST_IDLE: begin
                if (req.req_dn) begin
                    if (gate_en && sw_en) begin
                        state_n = ST_DN_ISO;
                        iso_n   = 1'b1;
                        ld      = 1'b1;
                        ld_v    = load_val(dn_dly.lead);
                    end else begin
                        clr.req_dn = 1'b1;
                        done_n     = 1'b1;
                    end
                end else if (req.req_up) begin
                    if (!sw_en) begin
                        state_n = ST_UP_SW;
                        sw_n    = 1'b1;
                        ld      = 1'b1;
                        ld_v    = load_val(up_dly.lead);
                    end else begin
                        clr.req_up = 1'b1;
                        done_n     = 1'b1;
                    end
                end
            end
            ST_DN_ISO: if (expired) begin
                state_n = ST_DN_SW;
                sw_n    = 1'b0;
                ld      = 1'b1;
                ld_v    = load_val(dn_dly.tail);
            end
            ST_DN_SW: if (expired) begin
                state_n    = ST_IDLE;
                clr.req_dn = 1'b1;
                done_n     = 1'b1;
            end
            ST_UP_SW: if (expired) begin
                state_n = ST_UP_ISO;
                iso_n   = 1'b0;
                ld      = 1'b1;
                ld_v    = load_val(up_dly.tail);
            end
            ST_UP_ISO: if (expired) begin
                state_n    = ST_IDLE;
                clr.req_up = 1'b1;
                done_n     = 1'b1;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            iso_en <= 1'b0;
            sw_en  <= 1'b1;
            done   <= 1'b0;
        end else begin
            state  <= state_n;
            iso_en <= iso_n;
            sw_en  <= sw_n;
            done   <= done_n;
        end
    end

    assign busy = (state != ST_IDLE);

    // R11
    iso_while_off_chk: assert property (@(posedge clk) disable iff (rst)
        !sw_en |-> iso_en);
    // R11
    sw_open_after_iso_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sw_en) |-> $past(iso_en));
    // R11
    iso_release_powered_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(iso_en) |-> $past(sw_en));
    // R7
    gate_blocks_down_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(iso_en) |-> $past(gate_en));
    // R4
    done_not_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
    // R8
    idle_outputs_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> ($stable(sw_en) && $stable(iso_en)));

endmodule

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq
    import pgs_pkg::*;
#(
    parameter logic [DLY_W-1:0] DLY_RST = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              iso_en,
    output logic              sw_en,
    output logic              busy,
    output logic              done
);

    logic       gate_en;
    phase_dly_t up_dly, dn_dly;
    req_t       req, clr;

    pgs_regs #(.DLY_RST(DLY_RST)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .gate_en   (gate_en),
        .up_dly    (up_dly),
        .dn_dly    (dn_dly),
        .req       (req),
        .clr       (clr)
    );

    pgs_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .gate_en (gate_en),
        .up_dly  (up_dly),
        .dn_dly  (dn_dly),
        .clr     (clr),
        .iso_en  (iso_en),
        .sw_en   (sw_en),
        .busy    (busy),
        .done    (done)
    );

endmodule

// File: tb/sim_pwr_gate_seq.sv
module sim_pwr_gate_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        iso_en, sw_en, busy, done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pwr_gate_seq u0 (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .iso_en(iso_en), .sw_en(sw_en), .busy(busy), .done(done)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // k counts negedges after the edge that latched the request
    task automatic run_seq(input bit down, input int e1, input int e2, input int ed,
                           input logic [31:0] exp_ctrl, input string tag);
        int k1 = -1, k2 = -1, kd = -1;
        bit busy_ok = 1;
        logic [31:0] v;
        for (int k = 1; k <= 200; k++) begin
            @(negedge clk);
            if (down) begin
                if (k1 < 0 && iso_en)  k1 = k;
                if (k2 < 0 && !sw_en)  k2 = k;
            end else begin
                if (k1 < 0 && sw_en)   k1 = k;
                if (k2 < 0 && !iso_en) k2 = k;
            end
            if (done) begin kd = k; break; end
            if (!busy) busy_ok = 0;
        end
        check({tag, " first step cycle"}, k1, e1);
        check({tag, " second step cycle"}, k2, e2);
        check({tag, " done cycle"}, kd, ed);
        check({tag, " busy during sequence"}, busy_ok, 1);
        check({tag, " busy low at done"}, busy, 0);
        rd(12'h000, v);
        check({tag, " ctrl after done"}, v, exp_ctrl);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 sw_en", sw_en, 1);
        check("R1 iso_en", iso_en, 0);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        rd(12'h260, v); check("R1 gate reg", v, 0);
        rd(12'h264, v); check("R1 up timing", v, 32'h0101);
        rd(12'h268, v); check("R1 down timing", v, 32'h0101);
        rd(12'h000, v); check("R1 ctrl", v, 0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(12'h268, 32'hFFFF_FFFF);
        rd(12'h268, v); check("R2 down timing mask", v, 32'h3F3F);
        wr(12'h264, 32'h0000_2A15);
        rd(12'h264, v); check("R2 up timing readback", v, 32'h2A15);
        rd(12'h100, v); check("R2 unmapped read", v, 0);
        wr(12'h000, 32'h0);
        rd(12'h000, v); check("R2 ctrl write zero", v, 0);
    endtask

    task automatic t_gate_block();
        logic [31:0] v;
        wr(12'h260, 0);
        wr(12'h000, 1);
        @(negedge clk);
        check("R7 retire done", done, 1);
        check("R7 sw unchanged", sw_en, 1);
        check("R7 iso unchanged", iso_en, 0);
        rd(12'h000, v); check("R7 ctrl cleared", v, 0);
        @(negedge clk);
        check("R7 sw still on", sw_en, 1);
        check("R7 iso still off", iso_en, 0);
    endtask

    task automatic t_noop(input logic [31:0] bits, input logic exp_sw, input logic exp_iso);
        logic [31:0] v;
        wr(12'h000, bits);
        @(negedge clk);
        check("R8 retire done", done, 1);
        check("R8 sw unchanged", sw_en, exp_sw);
        check("R8 iso unchanged", iso_en, exp_iso);
        rd(12'h000, v); check("R8 ctrl cleared", v, 0);
    endtask

    task automatic t_down_up();
        wr(12'h260, 1);
        wr(12'h268, 32'h0503);
        wr(12'h000, 1);
        run_seq(1, 1, 4, 9, 0, "R3 R4 down 3/5");
        t_noop(1, 0, 1);
        wr(12'h264, 32'h0200);
        wr(12'h000, 2);
        run_seq(0, 1, 2, 4, 0, "R5 R6 R10 up 0/2");
    endtask

    task automatic t_both();
        wr(12'h268, 32'h0101);
        wr(12'h264, 32'h0101);
        wr(12'h000, 3);
        run_seq(1, 1, 2, 3, 32'h2, "R9 down first");
        run_seq(0, 1, 2, 3, 0, "R9 up after");
    endtask

    task automatic t_zero_and_gate_up();
        wr(12'h268, 32'h0000);
        wr(12'h000, 1);
        run_seq(1, 1, 2, 3, 0, "R10 down zero delays");
        wr(12'h260, 0);
        wr(12'h000, 2);
        run_seq(0, 1, 2, 3, 0, "R7 up with gate off");
        wr(12'h260, 1);
    endtask

    task automatic t_max();
        wr(12'h268, 32'h3F3F);
        wr(12'h000, 1);
        run_seq(1, 1, 64, 127, 0, "R10 R3 down max");
        wr(12'h264, 32'h3F3F);
        wr(12'h000, 2);
        run_seq(0, 1, 64, 127, 0, "R10 R5 up max");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_gate_block();
        t_noop(2, 1, 0);
        t_down_up();
        t_both();
        t_zero_and_gate_up();
        t_max();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule